// File: doc/BRIEF.md
# ADC Autoscan Sequencer Controller

This block sequences a 12-bit successive-approximation converter through a programmed list of up to eight channel configurations. For each configuration it drives the sample/hold control and the trial DAC code toward the analog stub, reads back a one-bit comparator, and resolves the result MSB first. Each result goes into a sixteen-entry circular buffer that software can read through a random-access port.

A start request launches an operation. After an optional power-up settle delay, the block converts the configurations in list order. In single mode it stops after the last listed entry. In continuous mode it wraps to the first entry and keeps going until a stop request arrives. After a programmable number of stored samples it raises a data-available flag and records the buffer address it just wrote. A power-management abort ends everything at once.

The converter clock is an enable derived from the system clock. The divider code n gives one converter tick every n+1 system clocks.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A conversion spans 16 converter ticks. `sample_o` is high for the first 3 ticks, with `dac_code_o` at 0. Ticks 4 to 15 each try one bit, MSB first. `cmp_i`=1 means the input is at or above `dac_code_o`, and the bit is kept. The stored result equals the code the comparator resolves.
- R2: With divider code n, a converter tick occurs every n+1 system clocks. Back-to-back conversions therefore complete 16·(n+1) system clocks apart.
- R3: With `settle_skip_i`=0, the first conversion starts 20 converter ticks later than with `settle_skip_i`=1.
- R4: Configuration entry i sits at `cfg_list_i[4i+3:4i]` and is driven on `mux_sel_o` while it converts. Entries 0 to `last_cfg_i` are converted in order. In single mode (`cont_mode_i`=0), `busy_o` drops after entry `last_cfg_i` is stored.
- R5: In continuous mode, entry 0 follows entry `last_cfg_i` without a new settle delay. Operation continues until a stop request.
- R6: A stop request during a conversion lets that conversion finish and store its result. `busy_o` then drops, and no further result is produced.
- R7: Results are written to addresses 0 to 15 in rising order, wrapping from 15 to 0. Each write shows one cycle of `res_valid_o` with its address and data. `rd_data_o` returns the entry at `rd_addr_i`.
- R8: `da_flag_o` sets on the Nth stored sample of the current count. N is 1 for interval code 0 or 1, N equals the code for codes 2 to 8, N is 12 for code 9, and N is 16 for codes 10 to 15. Before the Nth sample of an operation the flag stays 0.
- R9: When the flag sets, `last_addr_o` takes the address written by that sample.
- R10: `da_clr_i` clears the flag, and accepting a new start also clears it. `irq_o` equals the flag gated by `da_ie_i`.
- R11: `pm_abort_i` forces `busy_o` low on the next cycle. The conversion in progress stores nothing, and the write pointer is unchanged.
- R12: A start request while `busy_o` is high has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_req_i | input | 1 | Start pulse (accepted only when idle) |
| stop_req_i | input | 1 | Stop pulse |
| cont_mode_i | input | 1 | 1 = continuous, 0 = single pass |
| clk_div_i | input | 3 | Converter tick divider code |
| settle_skip_i | input | 1 | 1 = skip power-up settle delay |
| last_cfg_i | input | 3 | Index of last configuration in the list |
| cfg_list_i | input | 32 | Eight 4-bit channel configurations |
| intv_code_i | input | 4 | Data-available interval code |
| da_clr_i | input | 1 | Clear data-available flag |
| da_ie_i | input | 1 | Interrupt enable |
| pm_abort_i | input | 1 | Power-management abort |
| cmp_i | input | 1 | Comparator result |
| sample_o | output | 1 | Sample/hold control |
| dac_code_o | output | 12 | Trial DAC code |
| mux_sel_o | output | 4 | Active channel configuration |
| busy_o | output | 1 | Operation running |
| res_valid_o | output | 1 | Result write strobe |
| res_addr_o | output | 4 | Address of written result |
| res_data_o | output | 12 | Written result |
| rd_addr_i | input | 4 | Buffer read address |
| rd_data_o | output | 12 | Buffer read data |
| da_flag_o | output | 1 | Data-available flag |
| last_addr_o | output | 4 | Address captured at flag set |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench's comparator model maps each configuration to a fixed analog level. The level table includes full scale (all ones) and zero, so a stuck or misordered bit trial shows up as a wrong code. The conversion is exercised in four settings:
- A single pass with the divider at 1.
- The same pass with the settle delay enabled. The latency difference between this pass and the previous one isolates the settle count.
- A continuous run with divider 3 and eight entries. This separates wrap-around of the configuration list from buffer-pointer wrap-around. It also checks the conversion period and the sample window at a non-unit ratio.
- A 16-sample continuous run, followed by an abort. Together with the interval codes 0, 5, 9 and 10, these runs distinguish the linear interval codes from the non-linear ones, the clear of the flag by a new start from its clear by software, and a completed stop from an abort that stores nothing.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int INTV_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } scan_state_e;

  // interval code -> sample count
  function automatic logic [INTV_W-1:0] intv_decode(input logic [3:0] code);
    logic [INTV_W-1:0] n;
    if (code <= 4'd1)      n = INTV_W'(1);
    else if (code <= 4'd8) n = INTV_W'(code);
    else if (code == 4'd9) n = INTV_W'(12);
    else                   n = INTV_W'(16);
    return n;
  endfunction
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIVW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o
);
  logic [DIVW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W   = 12,
  parameter int SMP_TCK = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int LATCH = SMP_TCK + RES_W;      // final phase index
  localparam int PH_W  = $clog2(LATCH + 1);

  logic [PH_W-1:0]  phase_q;
  logic [RES_W-1:0] acc_q;
  logic [PH_W-1:0]  bit_idx;
  logic             trial;
  logic [RES_W-1:0] mask;

  always_comb begin
    trial   = (phase_q >= PH_W'(SMP_TCK)) && (phase_q < PH_W'(LATCH));
    bit_idx = PH_W'(LATCH - 1) - phase_q;
    mask    = trial ? (RES_W'(1) << bit_idx) : '0;
  end

  assign dac_o    = acc_q | mask;
  assign sample_o = run_i && (phase_q < PH_W'(SMP_TCK));
  assign done_o   = run_i && tick_i && (phase_q == PH_W'(LATCH));
  assign result_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else if (!run_i) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else if (tick_i) begin
      if (phase_q == PH_W'(LATCH)) begin
        phase_q <= '0;
        acc_q   <= '0;
      end else begin
        if (trial && cmp_i) acc_q <= acc_q | mask;
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assert_sample_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (dac_o == '0));
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf
  import adc_scan_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RES_W-1:0]  wr_data_i,
  input  logic              new_op_i,
  input  logic              da_clr_i,
  input  logic [INTV_W-1:0] intv_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [RES_W-1:0]  rd_data_o,
  output logic              res_valid_o,
  output logic [AW-1:0]     res_addr_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic              da_flag_o,
  output logic [AW-1:0]     last_addr_o
);
  logic [RES_W-1:0]  mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q;
  logic [INTV_W-1:0] scnt_q;
  logic              hit;

  assign hit       = wr_en_i && ((scnt_q + 1'b1) == intv_i);
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q    <= '0;
      res_valid_o <= 1'b0;
      res_addr_o  <= '0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= wr_en_i;
      if (wr_en_i) begin
        res_addr_o <= wr_ptr_q;
        res_data_o <= wr_data_i;
        wr_ptr_q   <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_q      <= '0;
      da_flag_o   <= 1'b0;
      last_addr_o <= '0;
    end else if (new_op_i) begin
      scnt_q    <= '0;
      da_flag_o <= 1'b0;
    end else begin
      if (da_clr_i) da_flag_o <= 1'b0;
      if (wr_en_i) begin
        if (hit) begin
          da_flag_o   <= 1'b1;
          last_addr_o <= wr_ptr_q;
          scnt_q      <= '0;
        end else begin
          scnt_q <= scnt_q + 1'b1;
        end
      end
    end
  end

  assert_ptr_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ptr_q == AW'(DEPTH - 1)) |=> (wr_ptr_q == '0));
  assert_last_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !new_op_i) |=> (da_flag_o && last_addr_o == $past(wr_ptr_q)));
  assert_flag_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_op_i |=> !da_flag_o);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int DEPTH   = 16,
  parameter int NCFG    = 8,
  parameter int CFGW    = 4,
  parameter int DIVW    = 3,
  parameter int SETTLE  = 20,
  parameter int SMP_TCK = 3,
  localparam int AW     = $clog2(DEPTH),
  localparam int CIW    = $clog2(NCFG),
  localparam int SW     = $clog2(SETTLE + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_req_i,
  input  logic                 stop_req_i,
  input  logic                 cont_mode_i,
  input  logic [DIVW-1:0]      clk_div_i,
  input  logic                 settle_skip_i,
  input  logic [CIW-1:0]       last_cfg_i,
  input  logic [NCFG*CFGW-1:0] cfg_list_i,
  input  logic [3:0]           intv_code_i,
  input  logic                 da_clr_i,
  input  logic                 da_ie_i,
  input  logic                 pm_abort_i,
  input  logic                 cmp_i,
  output logic                 sample_o,
  output logic [RES_W-1:0]     dac_code_o,
  output logic [CFGW-1:0]      mux_sel_o,
  output logic                 busy_o,
  output logic                 res_valid_o,
  output logic [AW-1:0]        res_addr_o,
  output logic [RES_W-1:0]     res_data_o,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [RES_W-1:0]     rd_data_o,
  output logic                 da_flag_o,
  output logic [AW-1:0]        last_addr_o,
  output logic                 irq_o
);
  scan_state_e      state_q;
  logic [SW-1:0]    settle_q;
  logic [CIW-1:0]   ch_idx_q;
  logic             stop_pend_q;
  logic             tick, conv_done, new_op, last_ch;
  logic [RES_W-1:0] result;

  assign busy_o    = (state_q != ST_IDLE);
  assign new_op    = (state_q == ST_IDLE) && start_req_i && !pm_abort_i;
  assign last_ch   = (ch_idx_q == last_cfg_i);
  assign mux_sel_o = cfg_list_i[ch_idx_q*CFGW +: CFGW];
  assign irq_o     = da_flag_o && da_ie_i;

  adc_tick_gen #(.DIVW(DIVW)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  adc_sar_core #(.RES_W(RES_W), .SMP_TCK(SMP_TCK)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_CONV),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .sample_o (sample_o),
    .dac_o    (dac_code_o),
    .done_o   (conv_done),
    .result_o (result)
  );

  adc_result_buf #(.RES_W(RES_W), .DEPTH(DEPTH)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (conv_done && !pm_abort_i),
    .wr_data_i   (result),
    .new_op_i    (new_op),
    .da_clr_i    (da_clr_i),
    .intv_i      (intv_decode(intv_code_i)),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .res_valid_o (res_valid_o),
    .res_addr_o  (res_addr_o),
    .res_data_o  (res_data_o),
    .da_flag_o   (da_flag_o),
    .last_addr_o (last_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      settle_q    <= '0;
      ch_idx_q    <= '0;
      stop_pend_q <= 1'b0;
    end else if (pm_abort_i) begin
      state_q     <= ST_IDLE;
      stop_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_req_i) begin
          state_q     <= settle_skip_i ? ST_CONV : ST_SETTLE;
          settle_q    <= '0;
          ch_idx_q    <= '0;
          stop_pend_q <= 1'b0;
        end
        ST_SETTLE: begin
          if (stop_req_i) state_q <= ST_IDLE;
          else if (tick) begin
            if (settle_q == SW'(SETTLE - 1)) state_q <= ST_CONV;
            settle_q <= settle_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (stop_req_i) stop_pend_q <= 1'b1;
          if (conv_done) begin
            if (stop_pend_q || stop_req_i || (!cont_mode_i && last_ch)) begin
              state_q     <= ST_IDLE;
              stop_pend_q <= 1'b0;
            end else begin
              ch_idx_q <= last_ch ? '0 : ch_idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_abort_i |=> !busy_o);
  assert_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && conv_done && stop_pend_q && !pm_abort_i) |=> !busy_o);
  assert_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && conv_done && !cont_mode_i && last_ch) |=> !busy_o);
  assert_no_busy_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_req_i && !pm_abort_i && !conv_done && !stop_req_i) |=> busy_o);
endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_req = 0, stop_req = 0, cont_mode = 0, settle_skip = 1;
  logic [2:0]  clk_div = 0, last_cfg = 0;
  logic [31:0] cfg_list = 0;
  logic [3:0]  intv_code = 0;
  logic        da_clr = 0, da_ie = 0, pm_abort = 0, cmp;
  logic        sample_o, busy_o, res_valid_o, da_flag_o, irq_o;
  logic [11:0] dac_code_o, res_data_o, rd_data_o;
  logic [3:0]  mux_sel_o, res_addr_o, last_addr_o;
  logic [3:0]  rd_addr = 0;

  int checks = 0, errors = 0, cyc = 0;
  int run_id = 0, seen_id = 0, run_cnt = 0, samp = 0, prev_cyc = -1;
  int start_cyc = 0, lat = 0, exp_r = 1, exp_intv = 1, mptr = 0;
  bit done_flag = 0;
  logic [11:0] exp_q[$];
  logic [11:0] exp_mem [16];
  bit          written [16];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] vin(input logic [3:0] c);
    if (c == 4'd0)  return 12'h000;
    if (c == 4'd15) return 12'hFFF;
    return 12'(c * 273 + 3);
  endfunction

  assign cmp = (vin(mux_sel_o) >= dac_code_o);

  adc_scan_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_req_i(start_req), .stop_req_i(stop_req),
    .cont_mode_i(cont_mode), .clk_div_i(clk_div), .settle_skip_i(settle_skip),
    .last_cfg_i(last_cfg), .cfg_list_i(cfg_list), .intv_code_i(intv_code),
    .da_clr_i(da_clr), .da_ie_i(da_ie), .pm_abort_i(pm_abort), .cmp_i(cmp),
    .sample_o(sample_o), .dac_code_o(dac_code_o), .mux_sel_o(mux_sel_o),
    .busy_o(busy_o), .res_valid_o(res_valid_o), .res_addr_o(res_addr_o),
    .res_data_o(res_data_o), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o),
    .da_flag_o(da_flag_o), .last_addr_o(last_addr_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: scoreboard pop and timing checks
  always @(posedge clk) begin
    #2;
    if (run_id != seen_id) begin
      seen_id = run_id; run_cnt = 0; samp = 0; prev_cyc = -1;
    end
    if (res_valid_o) begin
      run_cnt++;
      if (exp_q.size() == 0) chk(0, "R11 unexpected result", res_data_o, 0);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk(res_data_o == e, "R1 result code", res_data_o, e);
        exp_mem[mptr] = e; written[mptr] = 1;
      end
      chk(res_addr_o == 4'(mptr), "R7 write address", res_addr_o, mptr);
      mptr = (mptr + 1) % 16;
      chk(samp == 3 * exp_r, "R1 sample window", samp, 3 * exp_r);
      if (prev_cyc >= 0) chk(cyc - prev_cyc == 16 * exp_r, "R2 period", cyc - prev_cyc, 16 * exp_r);
      else lat = cyc - start_cyc;
      prev_cyc = cyc; samp = 0;
      if (run_cnt % exp_intv == 0) begin
        chk(da_flag_o == 1'b1, "R8 flag at interval", da_flag_o, 1);
        chk(last_addr_o == res_addr_o, "R9 last address", last_addr_o, res_addr_o);
        chk(irq_o == da_ie, "R10 irq gating", irq_o, da_ie);
      end else if (run_cnt < exp_intv) begin
        chk(da_flag_o == 1'b0, "R8 flag before interval", da_flag_o, 0);
      end
    end
    if (sample_o) samp++;
  end

  task automatic start_run();
    @(negedge clk);
    start_cyc = cyc; run_id++; start_req = 1;
    @(negedge clk);
    start_req = 0;
  endtask

  task automatic push_seq(input int n);
    for (int i = 0; i < n; i++) begin
      int k;
      k = i % (int'(last_cfg) + 1);
      exp_q.push_back(vin(cfg_list[k*4 +: 4]));
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic wait_cnt(input int n);
    for (int i = 0; i < 20000 && run_cnt < n; i++) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop_req = 1; @(negedge clk); stop_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat_a;
    int n0;
    for (int i = 0; i < 16; i++) written[i] = 0;
    cfg_list = {4'd3, 4'd7, 4'd14, 4'd1, 4'd9, 4'd5, 4'd15, 4'd0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0, "R4 reset busy", busy_o, 0);
    chk(da_flag_o == 0, "R8 reset flag", da_flag_o, 0);
    chk(irq_o == 0, "R10 reset irq", irq_o, 0);
    chk(sample_o == 0, "R1 reset sample", sample_o, 0);

    // T1: single pass, interval code 0, start re-issued while busy
    clk_div = 0; exp_r = 1; settle_skip = 1; cont_mode = 0; last_cfg = 2;
    intv_code = 0; exp_intv = 1; da_ie = 1;
    push_seq(3);
    start_run();
    repeat (5) @(negedge clk);
    start_req = 1; @(negedge clk); start_req = 0;
    chk(busy_o == 1, "R12 start while busy", busy_o, 1);
    wait_idle();
    lat_a = lat;
    chk(run_cnt == 3, "R4 single pass count", run_cnt, 3);
    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    chk(busy_o == 0, "R4 busy drops", busy_o, 0);

    // T2: settle enabled, interval 5 never reached
    settle_skip = 0; intv_code = 5; exp_intv = 5;
    push_seq(3);
    start_run();
    wait_idle();
    chk(lat - lat_a == 20, "R3 settle delay", lat - lat_a, 20);
    chk(da_flag_o == 0, "R10 flag cleared by start", da_flag_o, 0);

    // T3: continuous, divider 3, interval code 9 (12), stop after 13
    settle_skip = 1; clk_div = 2; exp_r = 3; cont_mode = 1; last_cfg = 7;
    intv_code = 9; exp_intv = 12; da_ie = 0;
    push_seq(40);
    start_run();
    wait_cnt(13);
    n0 = run_cnt;
    pulse_stop();
    wait_idle();
    chk(run_cnt == n0 + 1, "R6 stop completes current", run_cnt, n0 + 1);
    exp_q.delete();
    repeat (40) @(negedge clk);
    chk(run_cnt == n0 + 1, "R6 nothing after stop", run_cnt, n0 + 1);
    da_ie = 1;
    @(negedge clk);
    chk(irq_o == 1, "R10 irq when enabled", irq_o, 1);
    da_clr = 1; @(negedge clk); da_clr = 0; @(negedge clk);
    chk(da_flag_o == 0, "R10 software clear", da_flag_o, 0);
    chk(irq_o == 0, "R10 irq cleared", irq_o, 0);

    // T4: continuous, divider 1, interval code 10 (16)
    clk_div = 0; exp_r = 1; intv_code = 10; exp_intv = 16; last_cfg = 4;
    push_seq(40);
    start_run();
    wait_cnt(16);
    pulse_stop();
    wait_idle();
    chk(run_cnt == 17, "R5 continuous run count", run_cnt, 17);
    exp_q.delete();

    // T5: abort mid-conversion
    intv_code = 1; exp_intv = 1;
    start_run();
    repeat (8) @(negedge clk);
    pm_abort = 1; @(negedge clk); pm_abort = 0;
    chk(busy_o == 0, "R11 abort busy", busy_o, 0);
    repeat (60) @(negedge clk);
    chk(run_cnt == 0, "R11 nothing stored", run_cnt, 0);
    cont_mode = 0; last_cfg = 0;
    push_seq(1);
    start_run();
    wait_idle();
    chk(run_cnt == 1, "R11 pointer kept after abort", run_cnt, 1);

    // T6: read port
    for (int a = 0; a < 16; a++) begin
      if (written[a]) begin
        rd_addr = 4'(a);
        #1;
        chk(rd_data_o == exp_mem[a], "R7 buffer read", rd_data_o, exp_mem[a]);
        @(negedge clk);
      end
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule